// File: doc/BRIEF.md
# Boot Image CRC Integrity Checker

This block is a start-up sequencer that proves a stored program image is intact before the rest of the system is let go. After a start pulse it powers up a word-wide CRC-32 engine and clears it. It then confirms that the engine reads its cleared value. Next it fetches every 32-bit word of the image through a memory read port, from the image base word address up to and including the signature word at the end of the used area. Finally it shuts the engine down and reports the outcome.

The image is signed at build time by appending the CRC of the payload as one more word. Because of this, the CRC of the payload together with the signature is zero for an intact image, and that is the only result that passes. The block refuses the check in two cases, and no word is read in either: when the engine does not read all ones after its clear, and when the end address lies below the base address. The release output, which lets downstream initialisation proceed, is raised only after a passing check.

Top module: `boot_crc_checker`

## Requirements
- R1: The CRC uses polynomial 0x04C11DB7, a cleared value of 0xFFFFFFFF, and no input or output bit reversal and no final inversion. Each 32-bit word is folded in most significant bit first.
- R2: After start, the engine clock enable (crc_clk_en_o) rises and the engine is cleared. If the engine value is then anything other than 0xFFFFFFFF, the check ends as a fail and mem_req_o never rises.
- R3: Words are requested at ascending word addresses from base_addr_i through end_addr_i inclusive. While mem_req_o is high and no mem_rvalid_i has been seen, the address holds steady.
- R4: A word is folded into the CRC only in the cycle where mem_rvalid_i is high, so any read latency gives the same result.
- R5: pass_o is 1 only when the CRC over all fetched words equals 0x00000000. A single flipped bit anywhere in the image gives a fail.
- R6: If end_addr_i is below base_addr_i at start, done_o rises on the next cycle with pass_o at 0. No memory read happens and the engine clock enable stays low.
- R7: done_o and pass_o hold their values until the next start. A start pulse while busy_o is high is ignored.
- R8: release_o is high only while done_o and pass_o are both high.
- R9: When done_o is high, crc_clk_en_o and mem_req_o are low.
- R10: A one-word image holding 0xFFFFFFFF (a signed empty image) passes, and a one-word image holding 0x00000000 fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle or done |
| base_addr_i | input | AW | Word address of the first image word |
| end_addr_i | input | AW | Word address of the signature word |
| mem_req_o | output | 1 | Read request, held until a valid is seen |
| mem_addr_o | output | AW | Word address of the current read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| crc_clk_en_o | output | 1 | CRC engine clock enable |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | Check finished, result valid |
| pass_o | output | 1 | Check result: 1 means the image is intact |
| release_o | output | 1 | Downstream start-up may proceed |

## Verification
Two events can land on the same clock edge: a new start pulse, and the valid of the signature word, which moves the sequencer from streaming to its final compare. The bench memory model provokes this by raising start in exactly the cycle it returns the last word. The run passes the test only if it still ends in a pass, with the same number of reads and with done held afterwards. Any other outcome means the stray start restarted or corrupted the sequence.

// File: rtl/boot_crc_pkg.sv
package boot_crc_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_CLEARED = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLK_ON,
    S_PROBE,
    S_STREAM,
    S_CHECK,
    S_CLK_OFF,
    S_DONE
  } chk_state_e;

  // whole-word fold, msb first, no reflection
  function automatic logic [CRC_W-1:0] crc_fold_word(
    input logic [CRC_W-1:0] crc,
    input logic [CRC_W-1:0] data,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] c;
    c = crc ^ data;
    for (int i = 0; i < CRC_W; i++) begin
      if (c[CRC_W-1]) c = (c << 1) ^ poly;
      else            c = c << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc32_word_engine.sv
module crc32_word_engine
  import boot_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = CRC_POLY,
  parameter logic [CRC_W-1:0] INIT = CRC_CLEARED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             clr_i,
  input  logic             fold_i,
  input  logic [CRC_W-1:0] data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  // clk_en_i stands in for a gated engine clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
    end else if (clk_en_i) begin
      if (clr_i)       crc_q <= INIT;
      else if (fold_i) crc_q <= crc_fold_word(crc_q, data_i, POLY);
    end
  end

  assign crc_o = crc_q;

  a_r4_hold_without_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clk_en_i && (clr_i || fold_i)) |=> $stable(crc_o));

  a_r2_clear_loads_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && clr_i) |=> crc_o == INIT);
endmodule

// File: rtl/boot_crc_fetch.sv
module boot_crc_fetch #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] end_i,
  input  logic          advance_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      end_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      end_q  <= end_i;
    end else if (advance_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == end_q);

  a_r3_addr_steps_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i && !last_o) |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/boot_crc_checker.sv
module boot_crc_checker
  import boot_crc_pkg::*;
#(
  parameter int              AW       = 16,
  parameter logic [CRC_W-1:0] CRC_INIT = CRC_CLEARED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    base_addr_i,
  input  logic [AW-1:0]    end_addr_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [CRC_W-1:0] mem_rdata_i,
  output logic             crc_clk_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             release_o
);
  chk_state_e state_q, state_d;
  logic pass_q, pass_d;
  logic start_ok, range_bad;
  logic eng_en, eng_clr, eng_fold;
  logic [CRC_W-1:0] crc;
  logic [AW-1:0] addr;
  logic last, advance;

  assign start_ok  = start_i && (state_q == S_IDLE || state_q == S_DONE);
  assign range_bad = end_addr_i < base_addr_i;

  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    unique case (state_q)
      S_IDLE, S_DONE: if (start_ok) begin
        pass_d  = 1'b0;
        state_d = range_bad ? S_DONE : S_CLK_ON;
      end
      S_CLK_ON:  state_d = S_PROBE;
      S_PROBE:   state_d = (crc == CRC_CLEARED) ? S_STREAM : S_CLK_OFF;
      S_STREAM:  if (mem_rvalid_i && last) state_d = S_CHECK;
      S_CHECK: begin
        pass_d  = (crc == '0);
        state_d = S_CLK_OFF;
      end
      S_CLK_OFF: state_d = S_DONE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
    end
  end

  assign eng_en   = (state_q == S_CLK_ON) || (state_q == S_PROBE) ||
                    (state_q == S_STREAM) || (state_q == S_CHECK);
  assign eng_clr  = (state_q == S_CLK_ON);
  assign eng_fold = (state_q == S_STREAM) && mem_rvalid_i;
  assign advance  = eng_fold && !last;

  crc32_word_engine #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_i (eng_en),
    .clr_i    (eng_clr),
    .fold_i   (eng_fold),
    .data_i   (mem_rdata_i),
    .crc_o    (crc)
  );

  boot_crc_fetch #(.AW(AW)) u_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_ok),
    .base_i    (base_addr_i),
    .end_i     (end_addr_i),
    .advance_i (advance),
    .addr_o    (addr),
    .last_o    (last)
  );

  assign mem_req_o    = (state_q == S_STREAM);
  assign mem_addr_o   = addr;
  assign crc_clk_en_o = eng_en;
  assign busy_o       = !(state_q == S_IDLE || state_q == S_DONE);
  assign done_o       = (state_q == S_DONE);
  assign pass_o       = pass_q;
  assign release_o    = done_o && pass_q;

  a_r3_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> mem_req_o && $stable(mem_addr_o));

  a_r2_bad_probe_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PROBE && crc != CRC_CLEARED) |=> !mem_req_o && !pass_o);

  a_r6_inverted_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && range_bad) |=> done_o && !pass_o && !crc_clk_en_o && !mem_req_o);

  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(pass_o));

  a_r7_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != S_CLK_OFF) |=> busy_o);

  a_r8_release_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> (done_o && pass_o));

  a_r9_quiet_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!crc_clk_en_o && !mem_req_o));
endmodule

// File: tb/boot_crc_checker_tb.sv
`timescale 1ns/1ps
module boot_crc_checker_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start_drv = 1'b0, poke_start = 1'b0, start_s;
  assign start_s = start_drv | poke_start;
  logic [AW-1:0] base_a = '0, end_a = '0;
  logic mem_req, rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] rdata = '0;
  logic clk_en, busy, done, pass, rel;

  boot_crc_checker #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s),
    .base_addr_i(base_a), .end_addr_i(end_a),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .crc_clk_en_o(clk_en), .busy_o(busy), .done_o(done),
    .pass_o(pass), .release_o(rel)
  );

  // second instance whose engine clears to a wrong value
  logic start_b = 1'b0;
  logic req_b, clken_b, busy_b, done_b, pass_b, rel_b;
  logic [AW-1:0] addr_b;
  boot_crc_checker #(.AW(AW), .CRC_INIT(32'h0000_0000)) u_dut_badinit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b),
    .base_addr_i(16'd0), .end_addr_i(16'd8),
    .mem_req_o(req_b), .mem_addr_o(addr_b),
    .mem_rvalid_i(1'b0), .mem_rdata_i(32'h0),
    .crc_clk_en_o(clken_b), .busy_o(busy_b), .done_o(done_b),
    .pass_o(pass_b), .release_o(rel_b)
  );

  logic [31:0] mem [0:63];
  int vectors = 0, miscompares = 0;
  int lat = 0, wait_cnt = 0, read_cnt = 0, addr_err = 0;
  logic [AW-1:0] exp_addr = '0;
  bit clk_seen = 0, req_seen_b = 0, clk_seen_b = 0, poke_arm = 0, finished = 0;

  // memory model: answers after lat idle cycles, checks address order
  always @(negedge clk) begin
    poke_start = 1'b0;
    if (clk_en) clk_seen = 1;
    if (req_b) req_seen_b = 1;
    if (clken_b) clk_seen_b = 1;
    if (mem_req) begin
      if (wait_cnt >= lat) begin
        rvalid = 1'b1;
        rdata = mem[mem_addr[5:0]];
        read_cnt++;
        if (mem_addr != exp_addr) addr_err++;
        if (poke_arm && mem_addr == end_a) begin
          poke_start = 1'b1;
          poke_arm = 0;
        end
        exp_addr = exp_addr + 1'b1;
        wait_cnt = 0;
      end else begin
        rvalid = 1'b0;
        wait_cnt++;
      end
    end else begin
      rvalid = 1'b0;
      wait_cnt = 0;
    end
  end

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ d[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic build(input int base, input int n, input logic [31:0] seed);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      mem[base+i] = (seed * 32'h9E37_79B9) ^ (i * 32'h0100_0193) ^ {i[7:0], 24'h5A5A5A};
      c = ref_crc(c, mem[base+i]);
    end
    mem[base+n] = c;
  endtask

  task automatic run(input int b, input int e, input int l, output bit got_done, output bit low_after);
    lat = l; exp_addr = b[AW-1:0]; read_cnt = 0; addr_err = 0; clk_seen = 0;
    @(negedge clk);
    base_a = b[AW-1:0]; end_a = e[AW-1:0]; start_drv = 1'b1;
    @(negedge clk);
    start_drv = 1'b0;
    low_after = !done;
    got_done = 0;
    for (int i = 0; i < 600; i++) begin
      if (done) begin got_done = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(!done && !pass && !rel && !mem_req && !clk_en && !busy, "R9 reset outputs idle",
        {26'd0, done, pass, rel, mem_req, clk_en, busy}, 32'd0);
  endtask

  task automatic t_good(input int b, input int n, input int l, input string tag);
    bit gd, la;
    build(b, n, 32'h1234 + b + n);
    run(b, b + n, l, gd, la);
    chk(gd, {tag, " R5 done reached"}, gd, 1);
    chk(la, {tag, " R7 done cleared by start"}, la, 1);
    chk(pass && rel, {tag, " R1 R5 R8 intact image passes"}, {pass, rel}, 2'b11);
    chk(read_cnt == n + 1, {tag, " R3 word count"}, read_cnt, n + 1);
    chk(addr_err == 0, {tag, " R3 R4 ascending addresses"}, addr_err, 0);
    repeat (15) @(negedge clk);
    chk(done && pass && !clk_en && !mem_req, {tag, " R7 R9 done held, engine off"},
        {done, pass, clk_en, mem_req}, 4'b1100);
  endtask

  task automatic t_corrupt;
    bit gd, la;
    build(0, 8, 32'hABCD);
    mem[3] = mem[3] ^ 32'h0000_0400;
    run(0, 8, 1, gd, la);
    chk(gd && !pass && !rel, "R5 R8 flipped bit fails", {gd, pass, rel}, 3'b100);
    chk(read_cnt == 9, "R3 corrupt image fully read", read_cnt, 9);
  endtask

  task automatic t_single;
    bit gd, la;
    mem[20] = 32'hFFFF_FFFF;
    run(20, 20, 0, gd, la);
    chk(gd && pass && read_cnt == 1, "R10 all-ones single word passes", {gd, pass, read_cnt[7:0]}, {2'b11, 8'd1});
    mem[21] = 32'h0;
    run(21, 21, 2, gd, la);
    chk(gd && !pass && !rel, "R10 zero single word fails", {gd, pass, rel}, 3'b100);
  endtask

  task automatic t_inverted;
    bit gd, la;
    run(30, 29, 0, gd, la);
    chk(gd && !pass && !rel, "R6 inverted range fails", {gd, pass, rel}, 3'b100);
    chk(read_cnt == 0 && !clk_seen, "R6 no read, engine untouched", {read_cnt[7:0], 7'd0, clk_seen}, 16'd0);
  endtask

  task automatic t_collision;
    bit gd, la;
    build(0, 6, 32'h77);
    poke_arm = 1;
    run(0, 6, 2, gd, la);
    chk(gd && pass, "R7 start on last valid ignored, pass kept", {gd, pass}, 2'b11);
    chk(read_cnt == 7 && addr_err == 0, "R7 R3 reads unaffected by stray start", read_cnt, 7);
    repeat (10) @(negedge clk);
    chk(done && read_cnt == 7, "R7 no restart after collision", {done, read_cnt[7:0]}, {1'b1, 8'd7});
  endtask

  task automatic t_bad_probe;
    bit gd;
    req_seen_b = 0; clk_seen_b = 0;
    @(negedge clk); start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    gd = 0;
    for (int i = 0; i < 50; i++) begin
      if (done_b) begin gd = 1; break; end
      @(negedge clk);
    end
    chk(gd && !pass_b && !rel_b, "R2 wrong cleared value fails", {gd, pass_b, rel_b}, 3'b100);
    chk(!req_seen_b && clk_seen_b, "R2 engine enabled but no read", {req_seen_b, clk_seen_b}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_good(0, 8, 0, "fast");
    t_good(0, 8, 3, "slow");
    t_good(40, 4, 1, "offset");
    t_corrupt;
    t_single;
    t_inverted;
    t_collision;
    t_bad_probe;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule